// File: doc/BRIEF.md
# Machine Cycle and Retire Counter Unit

This block keeps two 64-bit event counters for a 32-bit hart and maps them into the machine-level CSR space. One counts clock cycles. The other counts retired instructions. Software reaches each counter as a low and a high 32-bit half. A small inhibit register stops either counter. While the hart is halted for debug, neither counter moves.

The CSR port works in one cycle. Read data comes combinationally from the current register state. A write lands on the next rising clock edge.

A written half also takes the step it would have taken in that same cycle. As a result, a low half written with n and read on the following cycle shows n+1 while counting is live.

The performance-monitor counter and event-selector ranges are owned by this block and always read as zero. Every owned access raises a hit flag. The surrounding CSR file uses that flag to tell this block's addresses from the rest.

Top module: `mcounter_unit`

## Requirements
- R1: While reset is held, both counters and the inhibit register are zero, and reads of 0xB00, 0xB80, 0xB02, 0xB82 and 0x320 return 0.
- R2: The cycle counter (low half at 0xB00, high half at 0xB80) adds one on every clock while inhibit bit 0 is clear and `debug_halted` is low.
- R3: The retire counter (low half at 0xB02, high half at 0xB82) adds one on each clock where `instr_retired` is high, while inhibit bit 2 is clear and `debug_halted` is low.
- R4: A high half changes without a write only when its own low half steps from 0xFFFFFFFF to 0x00000000.
- R5: A low half written with n reads n+1 on the next cycle if it was counting in the write cycle, and n otherwise. A high half written with n reads n, or n+1 if its low half wrapped in that cycle.
- R6: A write to a low half leaves its high half unchanged in that cycle, even when the written value plus its step wraps.
- R7: The inhibit register at 0x320 keeps bit 0 (cycle) and bit 2 (retire). All other bits read 0. A new inhibit value gates counting from the next cycle on, and writing it leaves both counters unchanged.
- R8: While `debug_halted` is high, neither counter changes unless software writes it.
- R9: Addresses 0xB03–0xB1F, 0xB83–0xB9F and 0x323–0x33F raise `csr_hit`, read 0, and ignore writes.
- R10: Any other address leaves `csr_hit` low and returns 0 on `csr_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | CSR write data |
| csr_wen | input | 1 | CSR write strobe |
| csr_ren | input | 1 | CSR read strobe |
| instr_retired | input | 1 | One instruction retired this cycle |
| debug_halted | input | 1 | Hart is in Debug Mode |
| csr_rdata | output | 32 | Read data, zero when not an owned read |
| csr_hit | output | 1 | Access targets an address this block owns |

## Verification
A software write to a counter half and that half's own increment or carry can fall in the same cycle. The bench provokes this in three ways: it writes the cycle low half while counting is live, it writes the retire low half while holding `instr_retired` high, and it writes 0xFFFFFFFE so that the very next step carries into a preset high half. The result is judged one cycle after each write: the bench compares the read-back against n+1, n or the high half's carried value, all computed arithmetically.

// File: rtl/mcounter_pkg.sv
`timescale 1ns/1ps
package mcounter_pkg;

    localparam logic [11:0] ADDR_CYC_LO  = 12'hB00;
    localparam logic [11:0] ADDR_CYC_HI  = 12'hB80;
    localparam logic [11:0] ADDR_RET_LO  = 12'hB02;
    localparam logic [11:0] ADDR_RET_HI  = 12'hB82;
    localparam logic [11:0] ADDR_INHIBIT = 12'h320;

    localparam logic [11:0] HPM_LO_FIRST = 12'hB03;
    localparam logic [11:0] HPM_LO_LAST  = 12'hB1F;
    localparam logic [11:0] HPM_HI_FIRST = 12'hB83;
    localparam logic [11:0] HPM_HI_LAST  = 12'hB9F;
    localparam logic [11:0] EVT_FIRST    = 12'h323;
    localparam logic [11:0] EVT_LAST     = 12'h33F;

    localparam int INH_BIT_CYC = 0;
    localparam int INH_BIT_RET = 2;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CYC_LO,
        SEL_CYC_HI,
        SEL_RET_LO,
        SEL_RET_HI,
        SEL_INHIBIT,
        SEL_ZERO
    } cnt_sel_e;

endpackage

// File: rtl/mcounter_decode.sv
`timescale 1ns/1ps
module mcounter_decode
    import mcounter_pkg::*;
(
    input  logic [11:0] addr,
    output cnt_sel_e    sel,
    output logic        owned
);

    logic in_hpm_lo;
    logic in_hpm_hi;
    logic in_evt;

    assign in_hpm_lo = (addr >= HPM_LO_FIRST) && (addr <= HPM_LO_LAST);
    assign in_hpm_hi = (addr >= HPM_HI_FIRST) && (addr <= HPM_HI_LAST);
    assign in_evt    = (addr >= EVT_FIRST)    && (addr <= EVT_LAST);

    always_comb begin
        if (addr == ADDR_CYC_LO) begin
            sel = SEL_CYC_LO;
        end else if (addr == ADDR_CYC_HI) begin
            sel = SEL_CYC_HI;
        end else if (addr == ADDR_RET_LO) begin
            sel = SEL_RET_LO;
        end else if (addr == ADDR_RET_HI) begin
            sel = SEL_RET_HI;
        end else if (addr == ADDR_INHIBIT) begin
            sel = SEL_INHIBIT;
        end else if (in_hpm_lo || in_hpm_hi || in_evt) begin
            sel = SEL_ZERO;
        end else begin
            sel = SEL_NONE;
        end
    end

    assign owned = (sel != SEL_NONE);

endmodule

// File: rtl/mcounter_pair.sv
`timescale 1ns/1ps
module mcounter_pair #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_en,
    input  logic         wr_lo,
    input  logic         wr_hi,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] lo,
    output logic [W-1:0] hi
);

    localparam logic [W-1:0] ALL_ONES = '1;

    logic         lo_wrap;
    logic         hi_step;
    logic [W-1:0] lo_nxt;
    logic [W-1:0] hi_nxt;

    assign lo_wrap = inc_en && (lo == ALL_ONES);
    // A low-half write absorbs the carry of that cycle.
    assign hi_step = lo_wrap && !wr_lo;

    always_comb begin
        if (wr_lo) begin
            lo_nxt = wdata + W'(inc_en);
        end else begin
            lo_nxt = lo + W'(inc_en);
        end
        if (wr_hi) begin
            hi_nxt = wdata + W'(hi_step);
        end else begin
            hi_nxt = hi + W'(hi_step);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo <= '0;
            hi <= '0;
        end else begin
            lo <= lo_nxt;
            hi <= hi_nxt;
        end
    end

    assert_lo_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lo && inc_en) |=> (lo == $past(lo) + W'(1)));

    assert_lo_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lo && !inc_en) |=> $stable(lo));

    assert_hi_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hi && !(inc_en && lo == ALL_ONES)) |=> $stable(hi));

    assert_lo_write_no_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !wr_hi) |=> $stable(hi));

endmodule

// File: rtl/mcounter_unit.sv
`timescale 1ns/1ps
module mcounter_unit
    import mcounter_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [11:0]     csr_addr,
    input  logic [XLEN-1:0] csr_wdata,
    input  logic            csr_wen,
    input  logic            csr_ren,
    input  logic            instr_retired,
    input  logic            debug_halted,
    output logic [XLEN-1:0] csr_rdata,
    output logic            csr_hit
);

    localparam int NUM_CNT = 2;

    cnt_sel_e        sel;
    logic            owned;
    logic            inh_cyc;
    logic            inh_ret;
    logic [XLEN-1:0] inh_view;
    logic [XLEN-1:0] cnt_lo [NUM_CNT];
    logic [XLEN-1:0] cnt_hi [NUM_CNT];
    logic [NUM_CNT-1:0] inc_vec;
    logic [NUM_CNT-1:0] wr_lo_vec;
    logic [NUM_CNT-1:0] wr_hi_vec;

    mcounter_decode u_decode (
        .addr  (csr_addr),
        .sel   (sel),
        .owned (owned)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inh_cyc <= 1'b0;
            inh_ret <= 1'b0;
        end else if (csr_wen && sel == SEL_INHIBIT) begin
            inh_cyc <= csr_wdata[INH_BIT_CYC];
            inh_ret <= csr_wdata[INH_BIT_RET];
        end
    end

    always_comb begin
        inh_view              = '0;
        inh_view[INH_BIT_CYC] = inh_cyc;
        inh_view[INH_BIT_RET] = inh_ret;
    end

    assign inc_vec[0]   = !debug_halted && !inh_cyc;
    assign inc_vec[1]   = !debug_halted && !inh_ret && instr_retired;
    assign wr_lo_vec[0] = csr_wen && (sel == SEL_CYC_LO);
    assign wr_hi_vec[0] = csr_wen && (sel == SEL_CYC_HI);
    assign wr_lo_vec[1] = csr_wen && (sel == SEL_RET_LO);
    assign wr_hi_vec[1] = csr_wen && (sel == SEL_RET_HI);

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        mcounter_pair #(.W(XLEN)) u_pair (
            .clk    (clk),
            .rst_n  (rst_n),
            .inc_en (inc_vec[g]),
            .wr_lo  (wr_lo_vec[g]),
            .wr_hi  (wr_hi_vec[g]),
            .wdata  (csr_wdata),
            .lo     (cnt_lo[g]),
            .hi     (cnt_hi[g])
        );
    end

    always_comb begin
        csr_rdata = '0;
        if (csr_ren) begin
            unique case (sel)
                SEL_CYC_LO:  csr_rdata = cnt_lo[0];
                SEL_CYC_HI:  csr_rdata = cnt_hi[0];
                SEL_RET_LO:  csr_rdata = cnt_lo[1];
                SEL_RET_HI:  csr_rdata = cnt_hi[1];
                SEL_INHIBIT: csr_rdata = inh_view;
                SEL_ZERO:    csr_rdata = '0;
                SEL_NONE:    csr_rdata = '0;
                default:     csr_rdata = '0;
            endcase
        end
    end

    assign csr_hit = (csr_ren || csr_wen) && owned;

    assert_debug_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (debug_halted && !csr_wen) |=> (cnt_lo[0] == $past(cnt_lo[0]) &&
                                        cnt_lo[1] == $past(cnt_lo[1])));

    assert_miss_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_hit |-> (csr_rdata == '0));

    assert_inhibit_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_ren && csr_addr == ADDR_INHIBIT) |->
            (csr_rdata[1] == 1'b0 && csr_rdata[XLEN-1:3] == '0));

    assert_inhibit_no_disturb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wen && csr_addr == ADDR_INHIBIT && inh_cyc) |=> $stable(cnt_lo[0]));

endmodule

// File: tb/mcounter_unit_tb.sv
`timescale 1ns/1ps
module mcounter_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic        csr_wen = 1'b0;
    logic        csr_ren = 1'b0;
    logic        instr_retired = 1'b0;
    logic        debug_halted = 1'b0;
    logic [31:0] csr_rdata;
    logic        csr_hit;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mcounter_unit u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .csr_addr      (csr_addr),
        .csr_wdata     (csr_wdata),
        .csr_wen       (csr_wen),
        .csr_ren       (csr_ren),
        .instr_retired (instr_retired),
        .debug_halted  (debug_halted),
        .csr_rdata     (csr_rdata),
        .csr_hit       (csr_hit)
    );

    function automatic bit bench_owned(input int a);
        return (a == 'hB00) || (a == 'hB80) || (a == 'hB02) || (a == 'hB82) ||
               (a == 'h320) || (a >= 'hB03 && a <= 'hB1F) ||
               (a >= 'hB83 && a <= 'hB9F) || (a >= 'h323 && a <= 'h33F);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive a write at the current falling edge; returns at the next falling edge.
    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        csr_addr  = a;
        csr_wdata = d;
        csr_wen   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        csr_wen   = 1'b0;
    endtask

    // Sample a read in the current cycle, then advance one cycle.
    task automatic do_read(input logic [11:0] a, output logic [31:0] v, output logic h);
        csr_addr = a;
        csr_ren  = 1'b1;
        #1;
        v = csr_rdata;
        h = csr_hit;
        @(negedge clk);
        csr_ren = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL all watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic        h;
        logic [31:0] base;
        logic [31:0] hold;
        int          ones;

        // R1: reads while reset is held
        repeat (3) @(negedge clk);
        csr_ren = 1'b1;
        foreach (base[i]) begin end
        csr_addr = 12'hB00; #1; check("R1 cyc_lo", csr_rdata, 32'h0);
        csr_addr = 12'hB80; #1; check("R1 cyc_hi", csr_rdata, 32'h0);
        csr_addr = 12'hB02; #1; check("R1 ret_lo", csr_rdata, 32'h0);
        csr_addr = 12'hB82; #1; check("R1 ret_hi", csr_rdata, 32'h0);
        csr_addr = 12'h320; #1; check("R1 inhibit", csr_rdata, 32'h0);
        csr_ren = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: free-running cycle count over a span
        do_read(12'hB00, base, h);
        check("R2 hit", {31'b0, h}, 32'h1);
        repeat (9) @(negedge clk);
        do_read(12'hB00, v, h);
        check("R2 span", v, base + 32'd10);

        // R5: low-half write with live counting reads n+1
        for (int i = 0; i < 8; i++) begin
            logic [31:0] n;
            n = 32'h1234_0000 * i + 32'h0000_0F0F + i;
            do_write(12'hB00, n);
            do_read(12'hB00, v, h);
            check("R5 cyc_lo n+1", v, n + 32'd1);
        end

        // R5/R6: write 0xFFFFFFFF to low half; no carry into high
        do_write(12'hB80, 32'h0000_0005);
        do_read(12'hB80, v, h);
        check("R5 cyc_hi write", v, 32'h5);
        do_write(12'hB00, 32'hFFFF_FFFF);
        do_read(12'hB00, v, h);
        check("R6 lo wrap via write", v, 32'h0);
        do_read(12'hB80, v, h);
        check("R6 hi untouched", v, 32'h5);

        // R4: natural wrap carries into high half
        do_write(12'hB80, 32'h0000_0009);
        do_write(12'hB00, 32'hFFFF_FFFE);
        do_read(12'hB00, v, h);
        check("R4 lo at max", v, 32'hFFFF_FFFF);
        do_read(12'hB80, v, h);
        check("R4 hi carried", v, 32'hA);

        // R7: inhibit register, reserved bits, deferred effect
        do_write(12'h320, 32'hFFFF_FFFF);
        do_read(12'h320, v, h);
        check("R7 inhibit bits", v, 32'h5);
        do_read(12'hB00, hold, h);
        repeat (10) @(negedge clk);
        do_read(12'hB00, v, h);
        check("R7 cycle frozen", v, hold);
        do_write(12'h320, 32'h0000_0000);
        do_read(12'hB00, v, h);
        check("R7 no disturb", v, hold);
        do_read(12'hB00, v, h);
        check("R7 resumes next cycle", v, hold + 32'd1);

        // R3: retire counting under several strobe patterns, cycle inhibited
        do_write(12'h320, 32'h0000_0001);
        for (int p = 0; p < 6; p++) begin
            logic [15:0] pat;
            pat  = 16'hA5C3 ^ (16'h1111 * p) ^ (p * 16'h0101);
            base = 32'h100 * p;
            do_write(12'hB02, base);
            ones = 0;
            for (int b = 0; b < 16; b++) begin
                instr_retired = pat[b];
                if (pat[b]) ones++;
                @(negedge clk);
            end
            instr_retired = 1'b0;
            do_read(12'hB02, v, h);
            check("R3 retire count", v, base + ones);
        end

        // R5: retire low written while a retire happens reads n+1
        instr_retired = 1'b1;
        do_write(12'hB02, 32'h0000_0777);
        instr_retired = 1'b0;
        do_read(12'hB02, v, h);
        check("R5 ret_lo n+1", v, 32'h778);

        // R4: retire wrap into its high half
        do_write(12'hB82, 32'h0000_0002);
        do_write(12'hB02, 32'hFFFF_FFFF);
        instr_retired = 1'b1;
        @(negedge clk);
        instr_retired = 1'b0;
        do_read(12'hB02, v, h);
        check("R4 ret lo wrapped", v, 32'h0);
        do_read(12'hB82, v, h);
        check("R4 ret hi carried", v, 32'h3);

        // R7: retire inhibit bit 2 blocks retire counting
        do_write(12'h320, 32'h0000_0004);
        do_read(12'hB02, hold, h);
        instr_retired = 1'b1;
        repeat (5) @(negedge clk);
        instr_retired = 1'b0;
        do_read(12'hB02, v, h);
        check("R7 retire inhibited", v, hold);

        // R8: debug halt freezes both counters
        do_write(12'h320, 32'h0000_0000);
        do_read(12'hB02, hold, h);
        do_read(12'hB00, base, h);
        debug_halted  = 1'b1;
        instr_retired = 1'b1;
        repeat (20) @(negedge clk);
        instr_retired = 1'b0;
        do_read(12'hB00, v, h);
        check("R8 cycle frozen", v, base + 32'd1);
        do_read(12'hB02, v, h);
        check("R8 retire frozen", v, hold);
        debug_halted = 1'b0;
        @(negedge clk);

        // R9: read-zero ranges ignore writes and raise hit
        for (int a = 0; a < 4096; a++) begin
            if (bench_owned(a) && a != 'hB00 && a != 'hB80 && a != 'hB02 &&
                a != 'hB82 && a != 'h320) begin
                do_write(a[11:0], 32'hFFFF_FFFF);
                do_read(a[11:0], v, h);
                check("R9 zero read", v, 32'h0);
                check("R9 hit", {31'b0, h}, 32'h1);
            end
        end
        do_read(12'h320, v, h);
        check("R9 inhibit unchanged", v, 32'h0);

        // R10: every unowned address misses and reads zero
        for (int a = 0; a < 4096; a++) begin
            if (!bench_owned(a)) begin
                do_read(a[11:0], v, h);
                check("R10 miss data", v, 32'h0);
                check("R10 miss hit", {31'b0, h}, 32'h0);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule